// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Queue

This block takes an asynchronous serial input line and recovers 8-bit characters from it. Timing comes from an oversampling tick that runs at sixteen times the bit rate. The tick is a one-cycle enable in the block's own clock domain. An optional parity bit follows the eight data bits, and it can be checked for even or odd sense. Every recovered character is placed in a 16-entry queue. Each entry also carries three flags for that character alone: a framing fault, a parity fault and a line break. Software can therefore tell which character in a burst was damaged.

The queue is drained through a valid/ready read stream. `rd_valid_o` is high whenever an entry is held, and `rd_word_o` shows the oldest entry. An entry is removed on a clock edge where both `rd_valid_o` and `rd_ready_i` are high. While `rd_ready_i` is low the presented word does not change, so a consumer may stall for as long as it likes. The serial side cannot be stalled. A character that arrives while the queue is full is lost, and a sticky overrun flag records the loss.

The block drives three plain status outputs: not-empty, overrun and an idle timeout. The idle timeout lets a consumer collect a short burst of characters without polling. Control inputs are also plain levels: receiver enable, parity enable, parity sense, a 5-bit timeout limit and a queue clear. Software commonly programs the timeout limit to 5.

Top module: `uart_rx_tagged`

## Requirements
- R1: A read word holds the received data in bits [7:0], the framing-fault flag in bit 8, the parity-fault flag in bit 9 and the break flag in bit 10. Data bits arrive least significant first.
- R2: A low level seen on a tick while idle starts a frame only if the line is still low at the eighth tick after it. A shorter low pulse produces no entry.
- R3: When `par_enable_i` is 1, one parity bit follows the data. With `par_even_i` = 1 the data and parity bits together must hold an even number of ones, and with 0 an odd number. A mismatch sets bit 9. When `par_enable_i` is 0, no parity bit is expected and bit 9 is 0.
- R4: A stop position sampled low sets bit 8. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: A frame in which every sampled position is low (start, data, parity if enabled, and stop) is stored as a break: bit 10 and bit 8 are set, bit 9 is 0 and the data is 0, giving the word 0x500. A long low level yields exactly one entry.
- R6: While `fifo_clear_i` is 1, the queue is emptied and the overrun flag is cleared. The clear takes priority over a push or a pop in the same cycle.
- R7: A character that completes while 16 entries are held is dropped, and the stored entries are kept. `overrun_o` then sets and stays set until a clear.
- R8: While `rx_enable_i` is 0, no character is received and no entry is written.
- R9: `timeout_o` rises once the queue holds data and the receiver has been idle for `idle_limit_i` character times of 160 ticks each. The count restarts on every arrival, pop or clear. A limit of 0 disables the timeout, and the flag is never high while the queue is empty.
- R10: `rd_valid_o` is high exactly when the queue holds an entry. Entries leave in arrival order, one per cycle with `rd_valid_o` and `rd_ready_i` both high. `rd_word_o` is held stable while `rd_valid_o` is high and `rd_ready_i` is low.
- R11: `not_empty_o` is high whenever at least one entry is held and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Asynchronous serial input, idle high |
| os_tick_i | input | 1 | One-cycle enable at sixteen times the bit rate |
| rx_enable_i | input | 1 | Receiver enable |
| par_enable_i | input | 1 | Expect and check a parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 odd |
| idle_limit_i | input | 5 | Idle character times before timeout; 0 disables |
| fifo_clear_i | input | 1 | Empties the queue and clears overrun |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| rd_word_o | output | 11 | Oldest entry: {break, parity fault, framing fault, data} |
| not_empty_o | output | 1 | Queue holds at least one entry |
| overrun_o | output | 1 | Sticky: a character was dropped on a full queue |
| timeout_o | output | 1 | Idle timeout with data pending |

## Verification
The hardest condition to reach is overrun. It needs seventeen complete serial frames to arrive with no read in between. The bench then has to show that the seventeenth frame was dropped while the first sixteen survived in order. To get there, the bench streams seventeen distinct characters with `rd_ready_i` held low, and checks the flag between the sixteenth and seventeenth frames. It then drains and compares every entry, and finally confirms that the flag is still set until a clear. A second hard case is the break. The bench holds the line low for twelve bit times and confirms that this yields one tagged entry, not a run of false frames.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 3;
  localparam int TMO_W  = 5;

  typedef struct packed {
    logic              brk;
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HIGH
  } rxq_state_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxq_deframer.sv
module rxq_deframer import rxq_pkg::*; #(
  parameter int OS_RATE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  output logic       frame_valid_o,
  output rxq_entry_t frame_o,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rxq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;

  // Frame classification at the stop sample.
  logic brk_c, perr_c, ferr_c;
  always_comb begin
    ferr_c = ~line_i;
    brk_c  = ~line_i && (shift_q == '0) && (!par_en_i || !par_q);
    perr_c = par_en_i && !brk_c && ((^{shift_q, par_q}) ^ ~par_even_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      idx_q         <= '0;
      shift_q       <= '0;
      par_q         <= 1'b0;
      frame_valid_o <= 1'b0;
      frame_o       <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      if (!enable_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_HALF) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              par_q   <= 1'b0;
              state_q <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              par_q   <= line_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q         <= '0;
              frame_valid_o <= 1'b1;
              frame_o.data  <= brk_c ? '0 : shift_q;
              frame_o.ferr  <= ferr_c;
              frame_o.perr  <= perr_c;
              frame_o.brk   <= brk_c;
              state_q       <= line_i ? ST_IDLE : ST_WAIT_HIGH;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WAIT_HIGH: begin
            if (line_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic [AW:0]  count_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign count_o = wp_q - rp_q;
  assign full_o  = (count_o == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o && !clear_i;
  assign do_pop  = pop_i && (count_o != '0) && !clear_i;
  assign head_o  = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q[AW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (clear_i) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CHAR_TICKS = 160,
  parameter int TMO_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             armed_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int TW = $clog2(CHAR_TICKS);
  localparam logic [TW-1:0]    TICK_LAST = TW'(CHAR_TICKS - 1);
  localparam logic [TMO_W-1:0] CHAR_MAX  = '1;

  logic [TW-1:0]    tick_q;
  logic [TMO_W-1:0] chars_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      chars_q <= '0;
    end else if (restart_i || !armed_i) begin
      tick_q  <= '0;
      chars_q <= '0;
    end else if (tick_i) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        if (chars_q != CHAR_MAX) chars_q <= chars_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign expired_o = (limit_i != '0) && (chars_q >= limit_i);
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged import rxq_pkg::*; #(
  parameter int FIFO_DEPTH  = 16,
  parameter int OS_RATE     = 16,
  parameter int CHAR_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_line_i,
  input  logic              os_tick_i,
  input  logic              rx_enable_i,
  input  logic              par_enable_i,
  input  logic              par_even_i,
  input  logic [TMO_W-1:0]  idle_limit_i,
  input  logic              fifo_clear_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              not_empty_o,
  output logic              overrun_o,
  output logic              timeout_o
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic          line_s;
  logic          frame_v;
  rxq_entry_t    frame_w;
  logic          busy_w;
  logic          full_w;
  logic [AW:0]   fill_w;
  logic          pop_w;
  logic          expired_w;
  logic          overrun_q;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (rx_line_i),
    .sync_o  (line_s)
  );

  rxq_deframer #(.OS_RATE(OS_RATE)) u_deframer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (rx_enable_i),
    .tick_i        (os_tick_i),
    .line_i        (line_s),
    .par_en_i      (par_enable_i),
    .par_even_i    (par_even_i),
    .frame_valid_o (frame_v),
    .frame_o       (frame_w),
    .busy_o        (busy_w)
  );

  rxq_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (fifo_clear_i),
    .push_i      (frame_v),
    .push_data_i (frame_w),
    .pop_i       (pop_w),
    .head_o      (rd_word_o),
    .full_o      (full_w),
    .count_o     (fill_w)
  );

  assign not_empty_o = (fill_w != '0);
  assign rd_valid_o  = not_empty_o;
  assign pop_w       = rd_valid_o && rd_ready_i && !fifo_clear_i;

  rxq_idle_timer #(.CHAR_TICKS(OS_RATE * CHAR_BITS), .TMO_W(TMO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .restart_i (frame_v || pop_w || fifo_clear_i),
    .armed_i   (not_empty_o && !busy_w),
    .limit_i   (idle_limit_i),
    .expired_o (expired_w)
  );

  assign timeout_o = expired_w && not_empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_q <= 1'b0;
    else if (fifo_clear_i)      overrun_q <= 1'b0;
    else if (frame_v && full_w) overrun_q <= 1'b1;
  end

  assign overrun_o = overrun_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_enable,
  input logic        fifo_clear,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [10:0] rd_word,
  input logic        not_empty,
  input logic        overrun,
  input logic        timeout,
  input logic        frame_valid,
  input logic [AW:0] fill
);
  // R7: overrun is sticky until clear
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !fifo_clear |=> overrun);

  // R7: a frame completing on a full queue raises overrun
  a_r7_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && (fill == (AW+1)'(DEPTH)) && !fifo_clear |=> overrun);

  // R7: the queue never holds more than its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));

  // R6: clear empties the queue and drops overrun
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> !not_empty && !overrun);

  // R8: a disabled receiver produces no frames
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable && $past(!rx_enable) |-> !frame_valid);

  // R9: timeout only with data pending
  a_r9_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> not_empty);

  // R10: presented word holds under back-pressure
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !fifo_clear |=> rd_valid && $stable(rd_word));
endmodule

bind uart_rx_tagged rxq_checker #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_rxq_checker (
  .clk         (clk_i),
  .rst_n       (rst_ni),
  .rx_enable   (rx_enable_i),
  .fifo_clear  (fifo_clear_i),
  .rd_valid    (rd_valid_o),
  .rd_ready    (rd_ready_i),
  .rd_word     (rd_word_o),
  .not_empty   (not_empty_o),
  .overrun     (overrun_o),
  .timeout     (timeout_o),
  .frame_valid (frame_v),
  .fill        (fill_w)
);

// File: tb/uart_rx_tagged_tb_top.sv
`timescale 1ns/100ps
module uart_rx_tagged_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic        os_tick;
  logic        rx_en = 1'b1;
  logic        par_en = 1'b0;
  logic        par_even = 1'b1;
  logic [4:0]  limit = 5'd5;
  logic        clr = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [10:0] rd_word;
  logic        not_empty, overrun, timeout;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int tick_div = 1;
  int tdc = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdc <= (tdc + 1 >= tick_div) ? 0 : tdc + 1;
    cycles <= cycles + 1;
  end
  assign os_tick = (tick_div == 1) ? 1'b1 : (tdc == 0);

  uart_rx_tagged dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_line_i(line), .os_tick_i(os_tick),
    .rx_enable_i(rx_en), .par_enable_i(par_en), .par_even_i(par_even),
    .idle_limit_i(limit), .fifo_clear_i(clr), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .rd_word_o(rd_word), .not_empty_o(not_empty),
    .overrun_o(overrun), .timeout_o(timeout)
  );

  always @(posedge clk) begin
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bt();
    return 16 * tick_div;
  endfunction

  // R1 R3 R4 R5 expected word
  function automatic logic [10:0] exp_word(input logic [7:0] d, input logic pe,
      input logic ev, input logic pbit, input logic stopb);
    logic f, b, p;
    f = ~stopb;
    b = ~stopb && (d == 8'd0) && (!pe || !pbit);
    p = pe && !b && ((^d) ^ pbit ^ ~ev);
    return {b, p, f, (b ? 8'd0 : d)};
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic pbit, input logic stopb);
    line = 1'b0; wait_cyc(bt());
    for (int i = 0; i < 8; i++) begin line = d[i]; wait_cyc(bt()); end
    if (par_en) begin line = pbit; wait_cyc(bt()); end
    line = stopb; wait_cyc(bt());
    line = 1'b1; wait_cyc(bt());
  endtask

  task automatic read_word(output logic [10:0] w);
    int n = 0;
    while (!rd_valid && n < 2000) begin @(negedge clk); n++; end
    w = rd_word;
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
  endtask

  initial begin
    logic [10:0] w, w2;
    logic pb;
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(5);
    // reset state
    chk("R11 reset not_empty", not_empty, 0);
    chk("R10 reset rd_valid", rd_valid, 0);
    chk("R7 reset overrun", overrun, 0);
    chk("R9 reset timeout", timeout, 0);

    // R1 R3: sweep all data values with parity, sense and injected faults
    par_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d = 8'(v);
      par_even = d[1];
      pb = (par_even ? ^d : ~^d) ^ ((v % 7) == 3);
      send_frame(d, pb, 1'b1);
      chk("R11 not_empty after frame", not_empty, 1);
      read_word(w);
      chk("R1 R3 parity sweep word", w, exp_word(d, 1'b1, par_even, pb, 1'b1));
    end
    wait_cyc(2);
    chk("R11 empty after sweep", not_empty, 0);

    // R3: no parity, slower tick
    par_en = 1'b0;
    for (int v = 0; v < 16; v++) begin
      logic [7:0] d = 8'(v * 17 + 3);
      tick_div = (v < 8) ? 1 : 3;
      send_frame(d, 1'b0, 1'b1);
      read_word(w);
      chk("R3 no-parity word", w, exp_word(d, 1'b0, 1'b1, 1'b0, 1'b1));
    end
    tick_div = 1;

    // R4: framing fault then a clean frame
    send_frame(8'hA5, 1'b0, 1'b0);
    send_frame(8'h5A, 1'b0, 1'b1);
    read_word(w);
    chk("R4 framing fault word", w, 11'h1A5);
    read_word(w);
    chk("R4 next frame after fault", w, 11'h05A);

    // R5: long break -> one entry
    line = 1'b0; wait_cyc(12 * bt());
    line = 1'b1; wait_cyc(3 * bt());
    read_word(w);
    chk("R5 break word", w, 11'h500);
    wait_cyc(2);
    chk("R5 single break entry", not_empty, 0);

    // R2: short glitch ignored
    line = 1'b0; wait_cyc(4);
    line = 1'b1; wait_cyc(20 * bt());
    chk("R2 glitch no entry", not_empty, 0);

    // R8: disabled receiver
    rx_en = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b1);
    wait_cyc(5);
    chk("R8 disabled no entry", not_empty, 0);
    rx_en = 1'b1;
    wait_cyc(bt());

    // R10: back-pressure holds word
    send_frame(8'hC3, 1'b0, 1'b1);
    w = rd_word;
    wait_cyc(50);
    w2 = rd_word;
    chk("R10 valid under stall", rd_valid, 1);
    chk("R10 word stable under stall", w2, w);
    read_word(w);
    chk("R10 stalled word value", w, 11'h0C3);

    // R7: overrun
    for (int i = 0; i < 17; i++) begin
      send_frame(8'(i * 3 + 1), 1'b0, 1'b1);
      if (i == 15) chk("R7 no overrun at 16", overrun, 0);
    end
    chk("R7 overrun after 17th", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      read_word(w);
      chk("R7 R10 stored order kept", w, 11'(i * 3 + 1));
    end
    wait_cyc(2);
    chk("R11 drained", not_empty, 0);
    chk("R7 overrun sticky", overrun, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R6 overrun cleared", overrun, 0);

    // R6: clear with data held
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R11 two entries held", not_empty, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R6 clear empties", not_empty, 0);

    // R9: timeout with limit 2
    limit = 5'd2;
    send_frame(8'h77, 1'b0, 1'b1);
    wait_cyc(2 * 160 - 60);
    chk("R9 timeout not yet", timeout, 0);
    wait_cyc(80);
    chk("R9 timeout raised", timeout, 1);
    read_word(w);
    @(negedge clk);
    chk("R9 timeout cleared by pop", timeout, 0);

    // R9: limit 0 disables
    limit = 5'd0;
    send_frame(8'h78, 1'b0, 1'b1);
    wait_cyc(600);
    chk("R9 disabled timeout", timeout, 0);
    read_word(w);
    chk("R1 last word", w, 11'h078);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule